// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level tree of 4 KiB tables that sit in memory. A requester hands over the address with two attributes, write versus read and user versus supervisor. The walker then fetches one directory entry and, when that entry allows it, one table entry. Both fetches go through a memory read port that carries one read at a time. The result is either the physical address or a fault. A fault carries a compact cause code and echoes the faulting linear address.

A separate write port loads the root base, which is the physical address of the directory frame. All entries and the root are physical addresses, and the walker's own reads are not translated. Only one walk is in flight at a time. A new request is accepted only once the previous answer has been presented.

Top module: `lin_xlate_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `resp_valid` and `mem_req` are 0.
- R2: The first read of a walk targets the root base plus four times address bits 31..22. The root base is taken from bits 31..12 of the value written on `root_wdata`, and its low 12 bits are zero.
- R3: The second read targets bits 31..12 of the directory entry (low 12 bits zero) plus four times address bits 21..12.
- R4: A successful walk returns `resp_fault`=0, `resp_code`=0, `resp_paddr` = table entry bits 31..12 joined with address bits 11..0, and `resp_vaddr` = the request address.
- R5: An entry with bit 0 (present) clear ends the walk with a fault, and no further read is issued. `resp_code` is {cause[1:0], user, write, present, level}: bit 0 is the level (0 directory, 1 table), bit 1 is the entry's present bit, bit 2 is 1 for a write access, bit 3 is 1 for a user access, and bits 5..4 give the cause (01 absent, 10 permission, 11 reserved).
- R6: A write access faults with cause 10 at the first level whose entry has bit 1 clear.
- R7: A user access faults with cause 10 at the first level whose entry has bit 2 clear, so it succeeds only when both levels have bit 2 set.
- R8: A present entry with bit 7 or bit 8 set faults with cause 11. Between causes, absent wins over reserved, and reserved wins over permission.
- R9: At most one memory read is outstanding. `mem_req` is a one-cycle pulse per read. `req_ready` is 0 from acceptance until the response. `resp_valid` lasts exactly one cycle.
- R10: A root write in the same cycle as request acceptance does not affect that walk, which uses the previous root. Walks accepted later use the new root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the root base |
| root_wdata | input | 32 | New root base (bits 11..0 ignored) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for write access |
| req_user | input | 1 | 1 for user-mode access |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_paddr | output | 32 | Physical address on success |
| resp_code | output | 6 | Fault code, zero on success |
| resp_vaddr | output | 32 | Linear address of the walk |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Physical address of the entry read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry value |

## Verification
Two functions can land in the same cycle: loading the root base and accepting a request whose directory address depends on that base. The bench raises `root_we` and `req_valid` on the same clock edge. It checks that the first `mem_addr` of that walk still uses the old root, and that the next walk's first read uses the new root with its low bits dropped. Both are judged only at the memory port and in the translated result.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int LA_W    = 32;
  localparam int DIR_W   = 10;
  localparam int TBL_W   = 10;
  localparam int OFF_W   = 12;
  localparam int ENT_LOG = 2;
  localparam int CODE_W  = 6;
  localparam int IDX_PAD = LA_W - DIR_W - ENT_LOG;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_PDE = 2'd1,
    ST_READ_PTE = 2'd2,
    ST_DONE     = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_PERM   = 2'b10,
    CAUSE_RSVD   = 2'b11
  } fault_cause_e;

  function automatic logic [DIR_W-1:0] dir_index(input logic [LA_W-1:0] a);
    return a[LA_W-1 -: DIR_W];
  endfunction

  function automatic logic [TBL_W-1:0] tbl_index(input logic [LA_W-1:0] a);
    return a[OFF_W+TBL_W-1 -: TBL_W];
  endfunction

  function automatic logic [LA_W-1:0] frame_base(input logic [LA_W-1:0] e);
    return {e[LA_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [LA_W-1:0] entry_addr(input logic [LA_W-1:0] base,
                                                 input logic [DIR_W-1:0] idx);
    return base + {{IDX_PAD{1'b0}}, idx, {ENT_LOG{1'b0}}};
  endfunction
endpackage

// File: rtl/walk_root_reg.sv
module walk_root_reg
  import walk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [LA_W-1:0] wdata,
  output logic [LA_W-1:0] root_base
);
  logic [LA_W-1:0] root_q;
  always_ff @(posedge clk) begin
    if (!rst_n) root_q <= '0;
    else if (we) root_q <= frame_base(wdata);
  end
  assign root_base = root_q;
endmodule

// File: rtl/walk_entry_chk.sv
module walk_entry_chk
  import walk_pkg::*;
#(
  parameter logic [31:0] RSVD_MASK = 32'h0000_0180
) (
  input  logic [LA_W-1:0]   entry,
  input  logic              is_write,
  input  logic              is_user,
  input  logic              level,
  output logic              fault,
  output logic [CODE_W-1:0] code
);
  logic present, rsvd_hit, perm_bad;
  fault_cause_e cause;

  always_comb begin
    present  = entry[0];
    rsvd_hit = |(entry & RSVD_MASK);
    perm_bad = (is_write && !entry[1]) || (is_user && !entry[2]);
    if (!present)      cause = CAUSE_ABSENT;
    else if (rsvd_hit) cause = CAUSE_RSVD;
    else if (perm_bad) cause = CAUSE_PERM;
    else               cause = CAUSE_NONE;
    fault = (cause != CAUSE_NONE);
    code  = {cause, is_user, is_write, present, level};
  end
endmodule

// File: rtl/lin_xlate_walker.sv
module lin_xlate_walker
  import walk_pkg::*;
#(
  parameter logic [31:0] RSVD_MASK = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [LA_W-1:0]   root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [LA_W-1:0]   resp_paddr,
  output logic [CODE_W-1:0] resp_code,
  output logic [LA_W-1:0]   resp_vaddr,
  output logic              mem_req,
  output logic [LA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [LA_W-1:0]   mem_rdata
);
  walk_state_e       state_q;
  logic [LA_W-1:0]   vaddr_q, ptr_q, paddr_q, root_base;
  logic              wr_q, usr_q, issued_q, fault_q;
  logic [CODE_W-1:0] code_q;

  // named internal events
  logic accept, rd_beat, in_read, at_table, ent_fault;
  logic [CODE_W-1:0] ent_code;

  walk_root_reg u_root (
    .clk(clk), .rst_n(rst_n), .we(root_we), .wdata(root_wdata),
    .root_base(root_base)
  );

  assign in_read  = (state_q == ST_READ_PDE) || (state_q == ST_READ_PTE);
  assign at_table = (state_q == ST_READ_PTE);
  assign accept   = req_valid && req_ready;
  assign rd_beat  = mem_rvalid && in_read && issued_q;

  walk_entry_chk #(.RSVD_MASK(RSVD_MASK)) u_chk (
    .entry(mem_rdata), .is_write(wr_q), .is_user(usr_q), .level(at_table),
    .fault(ent_fault), .code(ent_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vaddr_q  <= '0;
      ptr_q    <= '0;
      paddr_q  <= '0;
      wr_q     <= 1'b0;
      usr_q    <= 1'b0;
      issued_q <= 1'b0;
      fault_q  <= 1'b0;
      code_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          vaddr_q  <= req_addr;
          wr_q     <= req_write;
          usr_q    <= req_user;
          ptr_q    <= entry_addr(root_base, dir_index(req_addr));
          issued_q <= 1'b0;
          state_q  <= ST_READ_PDE;
        end
        ST_READ_PDE: begin
          if (mem_req) issued_q <= 1'b1;
          if (rd_beat) begin
            if (ent_fault) begin
              fault_q <= 1'b1;
              code_q  <= ent_code;
              paddr_q <= '0;
              state_q <= ST_DONE;
            end else begin
              ptr_q    <= entry_addr(frame_base(mem_rdata), tbl_index(vaddr_q));
              issued_q <= 1'b0;
              state_q  <= ST_READ_PTE;
            end
          end
        end
        ST_READ_PTE: begin
          if (mem_req) issued_q <= 1'b1;
          if (rd_beat) begin
            fault_q <= ent_fault;
            code_q  <= ent_fault ? ent_code : '0;
            paddr_q <= ent_fault ? '0
                                 : {mem_rdata[LA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign resp_valid = (state_q == ST_DONE);
  assign resp_fault = fault_q;
  assign resp_code  = code_q;
  assign resp_paddr = paddr_q;
  assign resp_vaddr = vaddr_q;
  assign mem_req    = in_read && !issued_q;
  assign mem_addr   = ptr_q;
endmodule

// File: rtl/lin_xlate_walker_chk.sv
module lin_xlate_walker_chk
  import walk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic [LA_W-1:0]   resp_paddr,
  input logic [CODE_W-1:0] resp_code,
  input logic [LA_W-1:0]   resp_vaddr,
  input logic              mem_req,
  input logic [LA_W-1:0]   mem_addr,
  input logic              mem_rvalid
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req) outstanding <= 1'b1;
    else if (mem_rvalid) outstanding <= 1'b0;
  end

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && outstanding));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R9
  resp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == resp_vaddr[11:0]
                                     && resp_code == '0));

  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_code[5:4] != 2'b00));

  // R2
  aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind lin_xlate_walker lin_xlate_walker_chk u_walk_chk (.*);

// File: tb/tb_lin_xlate_walker.sv
module tb_lin_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr, resp_vaddr;
  logic [5:0]  resp_code;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  lin_xlate_walker dut (.*);

  int checks = 0;
  int errors = 0;
  int lat = 1;
  logic [31:0] mem_img [int unsigned];
  logic [31:0] rd_addr [4];
  int rd_cnt = 0;
  logic        r_fault;
  logic [31:0] r_paddr, r_vaddr;
  logic [5:0]  r_code;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mk_code(input logic [1:0] cause, input bit u, input bit w,
                                         input bit pres, input bit lvl);
    return {cause, u, w, pres, lvl};
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      while (mem_req) begin
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
        rd_cnt++;
        repeat (lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic load_root(input logic [31:0] v);
    @(negedge clk);
    root_we = 1'b1; root_wdata = v;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] a, input bit w, input bit u,
                      input bit with_root, input logic [31:0] rv);
    int t;
    @(negedge clk);
    rd_cnt = 0;
    req_addr = a; req_write = w; req_user = u; req_valid = 1'b1;
    if (with_root) begin root_we = 1'b1; root_wdata = rv; end
    @(negedge clk);
    req_valid = 1'b0; root_we = 1'b0;
    check("R9 ready low during walk", {31'b0, req_ready}, 32'h0);
    t = 0;
    while (!resp_valid && t < 100) begin @(negedge clk); t++; end
    check("R9 response arrives", {31'b0, resp_valid}, 32'h1);
    r_fault = resp_fault; r_paddr = resp_paddr; r_code = resp_code; r_vaddr = resp_vaddr;
    @(negedge clk);
    check("R9 resp one cycle", {31'b0, resp_valid}, 32'h0);
    check("R9 ready after resp", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic t_reset;
    check("R1 ready", {31'b0, req_ready}, 32'h1);
    check("R1 resp_valid", {31'b0, resp_valid}, 32'h0);
    check("R1 mem_req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_basic;
    walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 0);
    check("R2 dir addr", rd_addr[0], 32'h0010_0004);
    check("R3 tbl addr", rd_addr[1], 32'h0020_000C);
    check("R4 paddr", r_paddr, 32'h0055_5ABC);
    check("R4 no fault", {31'b0, r_fault}, 32'h0);
    check("R4 code zero", {26'b0, r_code}, 32'h0);
    check("R4 vaddr echo", r_vaddr, 32'h0040_3ABC);
    check("R9 two reads", rd_cnt, 2);
  endtask

  task automatic t_high_slow;
    lat = 4;
    walk(32'hFFEE_DDCC, 1'b0, 1'b0, 1'b0, 0);
    lat = 1;
    check("R2 dir addr top", rd_addr[0], 32'h0010_0FFC);
    check("R3 tbl addr", rd_addr[1], 32'h0030_0BB4);
    check("R4 paddr", r_paddr, 32'h0ABC_DDCC);
  endtask

  task automatic t_user_write_ok;
    walk(32'h0040_3ABC, 1'b1, 1'b1, 1'b0, 0);
    check("R7 user write ok", {31'b0, r_fault}, 32'h0);
    check("R7 paddr", r_paddr, 32'h0055_5ABC);
  endtask

  task automatic t_absent;
    walk(32'h0080_0000, 1'b0, 1'b1, 1'b0, 0);
    check("R5 dir absent code", {26'b0, r_code}, {26'b0, mk_code(2'b01, 1, 0, 0, 0)});
    check("R5 stop after dir", rd_cnt, 1);
    check("R5 fault vaddr", r_vaddr, 32'h0080_0000);
    walk(32'h0040_4010, 1'b0, 1'b0, 1'b0, 0);
    check("R5 tbl absent code", {26'b0, r_code}, {26'b0, mk_code(2'b01, 0, 0, 0, 1)});
    check("R5 tbl absent fault", {31'b0, r_fault}, 32'h1);
  endtask

  task automatic t_write_prot;
    walk(32'h0040_5123, 1'b1, 1'b0, 1'b0, 0);
    check("R6 tbl ro code", {26'b0, r_code}, {26'b0, mk_code(2'b10, 0, 1, 1, 1)});
    walk(32'h0040_5123, 1'b0, 1'b0, 1'b0, 0);
    check("R6 read of ro page", r_paddr, 32'h0066_6123);
    walk(32'h00C0_1000, 1'b1, 1'b0, 1'b0, 0);
    check("R6 dir ro code", {26'b0, r_code}, {26'b0, mk_code(2'b10, 0, 1, 1, 0)});
    check("R6 one read", rd_cnt, 1);
  endtask

  task automatic t_user_prot;
    walk(32'hFFEE_DDCC, 1'b0, 1'b1, 1'b0, 0);
    check("R7 dir supervisor code", {26'b0, r_code}, {26'b0, mk_code(2'b10, 1, 0, 1, 0)});
    walk(32'h0040_7000, 1'b0, 1'b1, 1'b0, 0);
    check("R7 tbl supervisor code", {26'b0, r_code}, {26'b0, mk_code(2'b10, 1, 0, 1, 1)});
  endtask

  task automatic t_reserved;
    walk(32'h0040_6000, 1'b0, 1'b0, 1'b0, 0);
    check("R8 tbl reserved", {26'b0, r_code}, {26'b0, mk_code(2'b11, 0, 0, 1, 1)});
    walk(32'h0100_0000, 1'b0, 1'b0, 1'b0, 0);
    check("R8 dir reserved", {26'b0, r_code}, {26'b0, mk_code(2'b11, 0, 0, 1, 0)});
    walk(32'h0140_0000, 1'b1, 1'b1, 1'b0, 0);
    check("R8 absent beats reserved", {26'b0, r_code}, {26'b0, mk_code(2'b01, 1, 1, 0, 0)});
  endtask

  task automatic t_root_collision;
    walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b1, 32'h0060_0FFF);
    check("R10 old root in flight", rd_addr[0], 32'h0010_0004);
    walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 0);
    check("R10 new root used", rd_addr[0], 32'h0060_0004);
    check("R2 root low bits dropped", r_paddr, 32'h0055_5ABC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem_img[32'h0010_0004] = 32'h0020_0007;
    mem_img[32'h0020_000C] = 32'h0055_5007;
    mem_img[32'h0010_0FFC] = 32'h0030_0003;
    mem_img[32'h0030_0BB4] = 32'h0ABC_D003;
    mem_img[32'h0020_0014] = 32'h0066_6005;
    mem_img[32'h0010_000C] = 32'h0040_0005;
    mem_img[32'h0020_0018] = 32'h0077_7087;
    mem_img[32'h0020_001C] = 32'h0088_8003;
    mem_img[32'h0010_0010] = 32'h0050_0107;
    mem_img[32'h0010_0014] = 32'h0000_0180;
    mem_img[32'h0060_0004] = 32'h0020_0007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_root(32'h0010_0000);
    t_basic();
    t_high_slow();
    t_user_write_ok();
    t_absent();
    t_write_prot();
    t_user_prot();
    t_reserved();
    t_root_collision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule